// File: doc/BRIEF.md
# Write-triggered SDRAM command issuer

This block sits in front of a low-power DDR SDRAM controller and turns ordinary host writes into SDRAM commands. Software first places a command code in a small operation register. While that code selects a command, the next host write into the memory window stores no data: the write is consumed, and the chosen command (NOP, precharge of all banks, auto-refresh or a mode-register load) is driven for one cycle on a compact command/address bus. For a mode-register load, the bank bits of the write address choose which device register is loaded (bank 2'b00 for the standard one, 2'b10 for the extended one), and the row bits of the address carry the value to load.

With the operation code at zero the block is transparent: host writes go straight through to the controller's data path. In that state a programmable refresh interval timer raises a refresh request every N controller clocks and launches an auto-refresh on the command bus as soon as the bus is free. A second register holds N. The first NOP that is issued also switches on the SDRAM clock enable, which stays on until reset.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset the operation code and the refresh interval read as 0, `cmd_valid` and `mem_clk_on` are low, and `host_ready` is high.
- R2: A configuration write with `cfg_sel`=0 stores `cfg_wdata[2:0]` as the operation code; with `cfg_sel`=1 it stores `cfg_wdata[11:0]` as the refresh interval. `cfg_rdata` returns the register picked by `cfg_sel`, zero-extended, in the same cycle.
- R3: With operation code 0, or one of the unused codes 5 to 7, a host write is forwarded in the same cycle on `mem_wr_valid`/`mem_wr_addr`/`mem_wr_data`, `host_ready` is high and no command is triggered.
- R4: With operation code 1 to 4 a host write is never forwarded; `host_ready` is low in the cycle the write is first presented, the command is on the bus in the following cycle for exactly one cycle, and `host_ready` is high in that cycle only.
- R5: `cmd_op` carries the operation code of the launched command: 1 = NOP, 2 = precharge all banks, 3 = mode-register load, 4 = auto-refresh. For every command except the load, `cmd_ba` and `cmd_a` are 0; with `cmd_valid` low all three are 0.
- R6: For a load, `cmd_ba` = `host_addr[23:22]` and `cmd_a` = `host_addr[21:10]` (byte bit 0, column bits 9:1, row bits 21:10, bank bits 23:22), so a write at offset 0x80_0000 gives bank 2'b10 and one at offset 0 gives 2'b00.
- R7: Each triggering write launches exactly one command; two writes under auto-refresh code give two separate one-cycle refresh commands with two handshakes.
- R8: `mem_clk_on` rises in the same cycle as the first NOP command appears on the bus and stays high until reset.
- R9: In normal mode with interval N > 0, a refresh request arises N cycles after the interval is written and every N cycles after that; the auto-refresh command (op 4) appears the cycle after the request, or later if the bus is busy, the request being held meanwhile.
- R10: An interval of 0 stops automatic refresh; under a non-zero operation code no automatic refresh is launched, any held request is dropped and the timer restarts from the full interval on the return to normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 = operation code register, 1 = refresh interval register |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read-back of the selected register |
| host_valid | input | 1 | Host write request, held until accepted |
| host_addr | input | 24 | Byte offset of the write within the memory window |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host write accepted in this cycle |
| mem_wr_valid | output | 1 | Forwarded data write to the controller core |
| mem_wr_addr | output | 24 | Forwarded write address |
| mem_wr_data | output | 16 | Forwarded write data |
| cmd_valid | output | 1 | Command present on the bus this cycle |
| cmd_op | output | 3 | Command code |
| cmd_ba | output | 2 | Bank address of the command |
| cmd_a | output | 12 | Address lines of the command |
| mem_clk_on | output | 1 | SDRAM clock enable |

## Verification
The bench goes after the handshake edge: a design that raised `host_ready` in the presentation cycle, or held the command for two cycles, would let the host see a write done before the command, or issue it twice. It checks the bank selection for both mode-register loads, which a design with the bank field off by one bit would send to the wrong register, and the back-to-back refresh writes, which a design that merged triggers would collapse into one command. The refresh interval is checked at N=1, where the request must wait out the busy bus every other cycle, and across mode switches, where a design that kept a stale request would refresh during the initialisation sequence.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // Operation codes; the launched command code equals the operation code.
  localparam logic [2:0] OP_NORMAL = 3'd0;
  localparam logic [2:0] OP_NOP    = 3'd1;
  localparam logic [2:0] OP_PALL   = 3'd2;
  localparam logic [2:0] OP_LOAD   = 3'd3;
  localparam logic [2:0] OP_AREF   = 3'd4;

  // Codes 1..4 turn the next host write into a command.
  function automatic logic is_cmd_code(input logic [2:0] code);
    return (code >= OP_NOP) && (code <= OP_AREF);
  endfunction

  // Value loaded into the down-counter so that expiry comes every n cycles.
  function automatic logic [15:0] reload_of(input logic [15:0] n);
    return (n == 16'd0) ? 16'd0 : n - 16'd1;
  endfunction

endpackage

// File: rtl/sdram_cmd_regs.sv
module sdram_cmd_regs
  import sdram_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [2:0]        op_code,
  output logic [CNT_W-1:0]  interval,
  output logic              interval_wr,
  output logic [CNT_W-1:0]  interval_new
);

  logic [2:0]       op_q;
  logic [CNT_W-1:0] ival_q;

  assign interval_wr  = cfg_we && cfg_sel;
  assign interval_new = cfg_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NORMAL;
      ival_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) ival_q <= interval_new;
      else         op_q   <= cfg_wdata[2:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) cfg_rdata[CNT_W-1:0] = ival_q;
    else         cfg_rdata[2:0]       = op_q;
  end

  assign op_code  = op_q;
  assign interval = ival_q;

endmodule

// File: rtl/sdram_refresh_tmr.sv
module sdram_refresh_tmr
  import sdram_cmd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] interval,
  input  logic             interval_wr,
  input  logic [CNT_W-1:0] interval_new,
  input  logic             ref_taken,
  output logic             ref_pend,
  output logic             expire
);

  logic [CNT_W-1:0] tmr_q;
  logic             pend_q;

  function automatic logic [CNT_W-1:0] rl(input logic [CNT_W-1:0] n);
    logic [15:0] w;
    w = reload_of(16'(n));
    return w[CNT_W-1:0];
  endfunction

  assign expire = run && (interval != '0) && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (interval_wr)                      tmr_q <= rl(interval_new);
      else if (!run || interval == '0)      tmr_q <= rl(interval);
      else if (tmr_q == '0)                 tmr_q <= rl(interval);
      else                                  tmr_q <= tmr_q - 1'b1;

      if (!run)          pend_q <= 1'b0;
      else if (expire)   pend_q <= 1'b1;
      else if (ref_taken) pend_q <= 1'b0;
    end
  end

  assign ref_pend = pend_q;

endmodule

// File: rtl/sdram_cmd_launch.sv
module sdram_cmd_launch
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ROW_LSB = 10,
  parameter int ROW_W  = 12,
  parameter int BA_LSB = 22,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              host_valid,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              ref_pend,
  output logic              cmd_mode,
  output logic              host_ready,
  output logic              trig,
  output logic              ref_launch,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_a,
  output logic              mem_clk_on
);

  logic              cv_q, ack_q, cke_q;
  logic [2:0]        op_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  a_q;

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] addr);
    return addr[BA_LSB +: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] addr);
    return addr[ROW_LSB +: ROW_W];
  endfunction

  assign cmd_mode   = is_cmd_code(op_code);
  assign trig       = host_valid && cmd_mode && !cv_q;
  assign ref_launch = ref_pend && !cmd_mode && !cv_q;
  assign host_ready = !cmd_mode || ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q  <= 1'b0;
      ack_q <= 1'b0;
      cke_q <= 1'b0;
      op_q  <= '0;
      ba_q  <= '0;
      a_q   <= '0;
    end else begin
      cv_q  <= trig || ref_launch;
      ack_q <= trig;
      if (trig && op_code == OP_NOP) cke_q <= 1'b1;
      if (trig) begin
        op_q <= op_code;
        ba_q <= (op_code == OP_LOAD) ? bank_of(host_addr) : '0;
        a_q  <= (op_code == OP_LOAD) ? row_of(host_addr)  : '0;
      end else if (ref_launch) begin
        op_q <= OP_AREF;
        ba_q <= '0;
        a_q  <= '0;
      end else begin
        op_q <= '0;
        ba_q <= '0;
        a_q  <= '0;
      end
    end
  end

  assign cmd_valid  = cv_q;
  assign cmd_op     = op_q;
  assign cmd_ba     = ba_q;
  assign cmd_a      = a_q;
  assign mem_clk_on = cke_q;

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 12,
  localparam int BYTE_LSB = $clog2(DATA_W / 8),
  localparam int ROW_LSB  = BYTE_LSB + COL_W,
  localparam int BA_LSB   = ROW_LSB + ROW_W,
  localparam int ADDR_W   = BA_LSB + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              host_valid,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_a,
  output logic              mem_clk_on
);

  // Internal events, named for the checker.
  logic [2:0]       op_code;
  logic [CNT_W-1:0] interval, interval_new;
  logic             interval_wr;
  logic             cmd_mode, mode_normal;
  logic             trig, ref_launch, ref_pend, expire;

  sdram_cmd_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .op_code(op_code), .interval(interval),
    .interval_wr(interval_wr), .interval_new(interval_new)
  );

  assign mode_normal = !cmd_mode;

  sdram_refresh_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(mode_normal),
    .interval(interval), .interval_wr(interval_wr),
    .interval_new(interval_new), .ref_taken(ref_launch),
    .ref_pend(ref_pend), .expire(expire)
  );

  sdram_cmd_launch #(
    .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB), .ROW_W(ROW_W),
    .BA_LSB(BA_LSB), .BANK_W(BANK_W)
  ) u_launch (
    .clk(clk), .rst_n(rst_n), .op_code(op_code),
    .host_valid(host_valid), .host_addr(host_addr), .ref_pend(ref_pend),
    .cmd_mode(cmd_mode), .host_ready(host_ready), .trig(trig),
    .ref_launch(ref_launch), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ba(cmd_ba), .cmd_a(cmd_a), .mem_clk_on(mem_clk_on)
  );

  assign mem_wr_valid = host_valid && mode_normal;
  assign mem_wr_addr  = host_addr;
  assign mem_wr_data  = host_wdata;

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              cmd_mode,
  input logic              mode_normal,
  input logic              ref_launch,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_ba,
  input logic [ROW_W-1:0]  cmd_a,
  input logic              mem_clk_on
);

  assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_ack_with_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && cmd_mode) |-> cmd_valid);

  assert_nonload_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 3'd3) |-> (cmd_ba == '0 && cmd_a == '0));

  assert_cke_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clk_on |=> mem_clk_on);

  assert_cke_on_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_clk_on) |-> (cmd_valid && cmd_op == 3'd1));

  assert_ref_normal_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_launch |-> mode_normal);

endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .cmd_mode(cmd_mode), .mode_normal(mode_normal), .ref_launch(ref_launch),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ba(cmd_ba), .cmd_a(cmd_a),
  .mem_clk_on(mem_clk_on)
);

// File: tb/sim_sdram_cmd_front.sv
`timescale 1ns/1ps
module sim_sdram_cmd_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        host_valid = 1'b0;
  logic [23:0] host_addr = '0, mem_wr_addr;
  logic [15:0] host_wdata = '0, mem_wr_data;
  logic        host_ready, mem_wr_valid, cmd_valid, mem_clk_on;
  logic [2:0]  cmd_op;
  logic [1:0]  cmd_ba;
  logic [11:0] cmd_a;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cmd_front u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_valid(host_valid),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ba(cmd_ba), .cmd_a(cmd_a), .mem_clk_on(mem_clk_on)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int m_mode, m_ival, m_tmr, m_pend, m_cv, m_op, m_ba, m_a, m_ack, m_cke;

  function automatic bit m_normal();
    return (m_mode == 0) || (m_mode > 4);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ival = 0; m_tmr = 0; m_pend = 0; m_cv = 0;
      m_op = 0; m_ba = 0; m_a = 0; m_ack = 0; m_cke = 0;
    end else begin
      automatic bit nrm = m_normal();
      automatic bit fire = host_valid && !nrm && !m_cv;
      automatic bit take = m_pend && nrm && !m_cv;
      automatic bit due = nrm && m_ival != 0 && m_tmr == 0;
      if (cfg_we && cfg_sel) m_tmr = (cfg_wdata[11:0] == 0) ? 0 : cfg_wdata[11:0] - 1;
      else if (!nrm || m_ival == 0 || m_tmr == 0) m_tmr = (m_ival == 0) ? 0 : m_ival - 1;
      else m_tmr = m_tmr - 1;
      if (!nrm) m_pend = 0; else if (due) m_pend = 1; else if (take) m_pend = 0;
      if (fire && m_mode == 1) m_cke = 1;
      m_op = fire ? m_mode : (take ? 4 : 0);
      m_ba = (fire && m_mode == 3) ? int'(host_addr[23:22]) : 0;
      m_a  = (fire && m_mode == 3) ? int'(host_addr[21:10]) : 0;
      m_cv = fire || take;
      m_ack = fire;
      if (cfg_we && !cfg_sel) m_mode = cfg_wdata[2:0];
      if (cfg_we && cfg_sel) m_ival = cfg_wdata[11:0];
    end
  end

  // Cycle comparison and event log, sampled after the edge has settled.
  int n_aref = 0, n_nop = 0, last_ref = -1, ref_gap = -1, cyc = 0;
  logic [1:0]  seen_ba;
  logic [11:0] seen_a;
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n && !done) begin
      automatic bit nrm = m_normal();
      chk("R4", "host_ready", host_ready, nrm || m_ack);
      chk("R3", "mem_wr_valid", mem_wr_valid, host_valid && nrm);
      chk("R9", "cmd_valid", cmd_valid, m_cv);
      chk("R5", "cmd_op", cmd_op, m_op);
      chk("R6", "cmd_ba", cmd_ba, m_ba);
      chk("R6", "cmd_a", cmd_a, m_a);
      chk("R8", "mem_clk_on", mem_clk_on, m_cke);
      chk("R2", "cfg_rdata", cfg_rdata, cfg_sel ? m_ival : m_mode);
      if (cmd_valid) begin
        seen_ba = cmd_ba; seen_a = cmd_a;
        if (cmd_op == 3'd1) n_nop++;
        if (cmd_op == 3'd4) begin
          n_aref++;
          if (last_ref >= 0) ref_gap = cyc - last_ref;
          last_ref = cyc;
        end
      end
    end
  end

  task automatic cfg_write(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 0; cfg_sel = 0;
  endtask

  // Presents a write and holds it until accepted; returns cycles waited.
  task automatic host_write(input int addr, output int waits);
    @(negedge clk);
    host_valid = 1; host_addr = 24'(addr); host_wdata = 16'hA5C3;
    waits = 0;
    forever begin
      if (host_ready) break;
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    host_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w, k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "mem_clk_on", mem_clk_on, 0);
    chk("R1", "host_ready", host_ready, 1);
    chk("R1", "op code", cfg_rdata, 0);

    // R3 pass-through in normal mode
    @(negedge clk); host_valid = 1; host_addr = 24'h12_3456;
    #1 chk("R3", "forwarded addr", mem_wr_addr, 24'h12_3456);
    chk("R3", "forwarded valid", mem_wr_valid, 1);
    @(negedge clk); host_valid = 0;

    // R8 NOP turns the clock on; R4 one stall cycle
    cfg_write(0, 1);
    host_write(24'h00_0040, w);
    chk("R4", "stall cycles", w, 1);
    chk("R8", "clock enable", mem_clk_on, 1);
    chk("R8", "nop count", n_nop, 1);

    // R5 precharge all at an arbitrary address: no bank/address
    cfg_write(0, 2);
    host_write(24'hFF_FFFE, w);
    chk("R5", "stall cycles", w, 1);

    // R7 two refresh writes, two commands
    cfg_write(0, 4);
    k = n_aref;
    host_write(24'h00_1000, w);
    host_write(24'h00_2000, w);
    chk("R7", "refresh commands", n_aref - k, 2);

    // R6 extended and standard register loads
    cfg_write(0, 3);
    host_write(24'h80_0000, w);
    chk("R6", "extended bank", seen_ba, 2);
    host_write(24'h00_8C00, w);
    chk("R6", "standard bank", seen_ba, 0);
    chk("R6", "load value", seen_a, 12'h023);

    // R3 reserved code behaves as normal
    cfg_write(0, 6);
    host_write(24'h00_0010, w);
    chk("R3", "reserved code stall", w, 0);
    chk("R8", "clock still on", mem_clk_on, 1);

    // R9 interval 7 in normal mode
    cfg_write(0, 0);
    cfg_write(1, 7);
    chk("R2", "interval readback", 0, 0);
    last_ref = -1; ref_gap = -1; k = n_aref;
    repeat (40) @(negedge clk);
    chk("R9", "refresh gap", ref_gap, 7);
    chk("R9", "refresh count", n_aref - k, 5);

    // R9 interval 1: request held through the busy cycle
    cfg_write(1, 1);
    last_ref = -1; ref_gap = -1;
    repeat (12) @(negedge clk);
    chk("R9", "held gap", ref_gap, 2);

    // R10 no automatic refresh under a command code
    cfg_write(1, 5);
    cfg_write(0, 1);
    k = n_aref;
    repeat (30) @(negedge clk);
    chk("R10", "refresh under command code", n_aref - k, 0);

    // R10 interval zero stops refresh
    cfg_write(0, 0);
    cfg_write(1, 0);
    k = n_aref;
    repeat (30) @(negedge clk);
    chk("R10", "refresh with zero interval", n_aref - k, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule